// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat burst access. When the load strobe is high at a rising clock edge, it captures a full external address. The captured value is the start of the burst. Each later edge at which the active-low advance input is low steps the two least significant address bits to the next beat. The upper bits keep the loaded value for the whole burst.

The step order is chosen at run time by a single order input. Low selects plain modulo-4 counting from the start value. High selects an interleaved order, in which beat n is the start value XORed with n. The system ties the order input high when it wants the default, interleaved order. After four beats the address returns to the start value; it never moves on to the next aligned block. A clock edge with advance high holds the burst where it is. A load always wins over an advance in the same cycle.

The beat count is kept in its own small counter, apart from the loaded address. The output is formed from the loaded start bits, the beat count and the current order input.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after its release with no load, the address output is zero.
- R2: When `load_i` is high at a rising edge, `addr_o` equals the sampled `addr_i` after that edge, whatever `adv_n_i` is.
- R3: With `order_i` = 0, the two LSBs of `addr_o` at beat n are (start + n) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `order_i` = 1, the two LSBs of `addr_o` at beat n are start XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R5: After the fourth beat, the next advance returns the two LSBs to the loaded start value in both orders.
- R6: A rising edge with `load_i` = 0 and `adv_n_i` = 1 leaves the beat position unchanged, so `addr_o` repeats its value.
- R7: A load in the same cycle as an asserted advance restarts at beat 0 of the new address; the advance is dropped.
- R8: Bits above the two LSBs of `addr_o` change only on a load; advances never carry into them.
- R9: `order_i` acts on the output in the same cycle. Changing it mid-burst remaps the current beat without changing the beat position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `addr_i` as a new burst start |
| addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
A load or an advance shows on `addr_o` one clock edge after it is sampled. The order input changes the output within the same cycle. The bench drives every input at the falling edge and advances its reference model at that moment. It then compares `addr_o` with the model at the next falling edge, after exactly one rising edge, using the order value that is still applied. The directed phases cover wrap, hold, load-over-advance and a mid-burst order change. A pseudo-random phase then mixes loads, advances, holds and order changes on every cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;

   // log2 of the burst length; four beats by default
   localparam int unsigned BAG_BEAT_BITS = 2;

   typedef enum logic {
      BAG_ORDER_LINEAR     = 1'b0,
      BAG_ORDER_INTERLEAVE = 1'b1
   } bag_order_e;

endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] base_o
);

   if (ADDR_W < 1) begin : g_bad_width
      $error("bag_base_reg: ADDR_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_o <= '0;
      else if (load_i)
         base_o <= addr_i;
   end

   // R2: a load lands in the register on the following edge
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> base_o == $past(addr_i));

   // R8: the start register is not disturbed without a load
   a_r8_base_still: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(base_o));

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [CTR_W-1:0] beat_o
);

   localparam logic [CTR_W-1:0] ONE  = CTR_W'(1);
   localparam logic [CTR_W-1:0] LAST = '1;

   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_width
      $error("bag_beat_ctr: CTR_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_o <= '0;
      else if (clr_i)
         beat_o <= '0;
      else if (step_i)
         beat_o <= beat_o + ONE;
   end

   // R7: a clear wins over a simultaneous step
   a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && step_i) |=> beat_o == '0);

   // R6: no step and no clear keeps the position
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !step_i) |=> $stable(beat_o));

   // R5: stepping from the last beat returns to beat zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && step_i && beat_o == LAST) |=> beat_o == '0);

endmodule

// File: rtl/bag_lsb_map.sv
module bag_lsb_map #(
   parameter int unsigned CTR_W = 2
) (
   input  logic             order_i,
   input  logic [CTR_W-1:0] start_i,
   input  logic [CTR_W-1:0] beat_i,
   output logic [CTR_W-1:0] lsb_o
);

   import bag_pkg::*;

   logic [CTR_W-1:0] lin_seq;
   logic [CTR_W-1:0] ilv_seq;

   // linear order: modulo add, carry out of the field is discarded
   assign lin_seq = start_i + beat_i;

   // interleaved order: each bit flips independently
   for (genvar b = 0; b < CTR_W; b++) begin : g_ilv_bit
      assign ilv_seq[b] = start_i[b] ^ beat_i[b];
   end

   always_comb begin
      unique case (bag_order_e'(order_i))
         BAG_ORDER_LINEAR:     lsb_o = lin_seq;
         BAG_ORDER_INTERLEAVE: lsb_o = ilv_seq;
         default:              lsb_o = ilv_seq;
      endcase
   end

   // R3/R4: beat zero maps to the start value in either order
   always_comb begin
      if (beat_i == '0)
         a_r4_beat0_is_start: assert (lsb_o == start_i);
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              adv_n_i,
   input  logic              order_i,
   output logic [ADDR_W-1:0] addr_o
);

   import bag_pkg::*;

   localparam int unsigned CTR_W = BAG_BEAT_BITS;
   localparam int unsigned UP_W  = ADDR_W - CTR_W;

   if (ADDR_W <= CTR_W) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must exceed the beat field width");
   end

   logic [ADDR_W-1:0] base_q;
   logic [CTR_W-1:0]  beat_q;
   logic [CTR_W-1:0]  lsb_w;

   bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .addr_i (addr_i),
      .base_o (base_q)
   );

   bag_beat_ctr #(.CTR_W(CTR_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load_i),
      .step_i (!adv_n_i),
      .beat_o (beat_q)
   );

   bag_lsb_map #(.CTR_W(CTR_W)) u_map (
      .order_i (order_i),
      .start_i (base_q[CTR_W-1:0]),
      .beat_i  (beat_q),
      .lsb_o   (lsb_w)
   );

   assign addr_o = {base_q[ADDR_W-1:CTR_W], lsb_w};

   // R2: the output shows the loaded address one edge later
   a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> addr_o == $past(addr_i));

   // R8: upper bits move only with a load
   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> addr_o[ADDR_W-1:CTR_W] == $past(addr_o[ADDR_W-1:CTR_W]));

   // R6: a held cycle with a steady order repeats the output
   a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) ##1 $stable(order_i) |-> $stable(addr_o));

   // R1: while reset is asserted the output is zero
   always_comb begin
      if (!rst_n)
         a_r1_reset_zero: assert (addr_o == '0 || UP_W == 0);
   end

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          adv_n_i = 1'b1;
   logic          order_i = 1'b1;
   logic [AW-1:0] addr_o;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   int m_base = 0;
   int m_beat = 0;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .addr_i  (addr_i),
      .adv_n_i (adv_n_i),
      .order_i (order_i),
      .addr_o  (addr_o)
   );

   function automatic int expected(input int ord);
      int s, l;
      s = m_base % 4;
      if (ord != 0) l = s ^ m_beat;
      else          l = (s + m_beat) % 4;
      return (m_base - s) + l;
   endfunction

   task automatic compare(input string tag);
      int e;
      e = expected(int'(order_i));
      n_cmp++;
      if (int'(addr_o) != e) begin
         n_bad++;
         $display("FAIL %s: addr_o=%05h expected=%05h", tag, addr_o, e[AW-1:0]);
      end
   endtask

   // called at a falling edge: apply, update model, check after one rising edge
   task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic advn,
                      input logic ord, input string tag);
      load_i  = ld;
      addr_i  = a;
      adv_n_i = advn;
      order_i = ord;
      if (ld) begin
         m_base = int'(a);
         m_beat = 0;
      end else if (!advn) begin
         m_beat = (m_beat + 1) % 4;
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(5ns * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // linear, start LSBs 01
      cyc(1'b1, 17'h12345, 1'b1, 1'b0, "R2 load linear");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R3 beat1");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R3 beat2");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R3 beat3 R8 no carry");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R5 linear wrap");
      cyc(1'b0, 17'h1FFFF, 1'b1, 1'b0, "R6 hold a");
      cyc(1'b0, 17'h1FFFF, 1'b1, 1'b0, "R6 hold b");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R6 resume");

      // interleaved, start LSBs 10
      cyc(1'b1, 17'h0F0F2, 1'b1, 1'b1, "R2 load interleave");
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R4 beat1");
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R4 beat2");
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R4 beat3");
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R5 interleave wrap");

      // load together with advance
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R4 step");
      cyc(1'b1, 17'h1AAA7, 1'b0, 1'b1, "R7 load over advance");
      cyc(1'b0, 17'h00000, 1'b0, 1'b1, "R7 next beat");

      // order change mid-burst remaps the current beat
      cyc(1'b0, 17'h00000, 1'b1, 1'b0, "R9 order to linear");
      cyc(1'b0, 17'h00000, 1'b1, 1'b1, "R9 order back");
      cyc(1'b0, 17'h00000, 1'b0, 1'b0, "R9 step linear");

      // mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = {lfsr[0], lfsr};
         cyc(lfsr[3:0] == 4'h5, a, lfsr[6] & lfsr[9], lfsr[11], "R8 mixed");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule